// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache with Grant-Triggered Flush

This block places a small direct-mapped cache between a fast 16-bit CPU bus and a slow main memory that other bus masters also use. Each line holds one 16-bit word together with a tag and a valid flag. A CPU read that finds a valid line with a matching tag is answered from the cache. Any other read goes to main memory, and the word that comes back is placed in the line. Every CPU write goes to main memory. If the line being written is present, its cached copy is updated as well.

Coherency does not depend on snooping. When another bus master acknowledges a bus grant (`alt_grant_ack`), every valid flag is cleared at once. While that acknowledge is high, the block reports no hits. Masters that only read memory, such as a display fetcher, do not need to raise the acknowledge, because they cannot make cached data stale. Capacity is set by `CACHE_BYTES`, which may range from 8 KB to 64 KB. The tag width follows from the capacity and `ADDR_W`.

The controller is a five-state machine:
- `CS_IDLE` latches a request when `cpu_req` rises and moves to `CS_LOOKUP`.
- `CS_LOOKUP` goes to `CS_ACK` on a read hit, to `CS_FILL` on a read miss, and to `CS_WRITE` for any write.
- `CS_FILL` and `CS_WRITE` hold `mem_req` until `mem_ack` arrives and then move to `CS_ACK`.
- `CS_ACK` holds `cpu_ack` high until `cpu_req` is released and then returns to `CS_IDLE`.

Top module: `wt_cache`

## Requirements
- R1: After reset, `cpu_ack` and `mem_req` are low and every line is invalid, so the first read of any address issues a memory read.
- R2: Every CPU write issues exactly one memory write with the same word address, data and byte strobes. `cpu_ack` rises only after `mem_ack`.
- R3: On a read miss, the block holds `mem_req` (address stable) until `mem_ack` and returns the memory word on `cpu_rdata`. The line becomes valid, so the next read of that address is a hit.
- R4: A read hit returns the cached word with no memory request. `cpu_ack` is high in the second cycle after `cpu_req` is first sampled. `mem_req` and `cpu_ack` are never high together.
- R5: A write miss does not allocate a line, so a later read of that address still misses.
- R6: A write hit updates the cached word in the cycle the memory write completes, so a later read hits and returns the written data.
- R7: Byte strobes are `cpu_be[1]` for bits 15:8 and `cpu_be[0]` for bits 7:0. A write hit changes only the selected bytes of the cached word.
- R8: A cycle with `alt_grant_ack` high clears all valid flags, so every line that was cached misses afterwards.
- R9: While `alt_grant_ack` is high, no read hits, and a fill that completes in that time leaves the line invalid.
- R10: The tag is compared by bitwise XOR equality. Two addresses with the same index but different tags evict each other, and each misses after the other has been read.
- R11: `cpu_ack` stays high while `cpu_req` stays high and falls in the cycle after `cpu_req` is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU cycle request, held until acknowledged |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W-1 | CPU word address |
| cpu_be | input | 2 | Byte strobes, bit 1 upper, bit 0 lower |
| cpu_wdata | input | 16 | CPU write data |
| cpu_rdata | output | 16 | Read data, valid while cpu_ack is high |
| cpu_ack | output | 1 | Cycle acknowledge, held until cpu_req falls |
| mem_req | output | 1 | Backing memory request, held until mem_ack |
| mem_we | output | 1 | Backing memory write |
| mem_addr | output | ADDR_W-1 | Backing memory word address |
| mem_be | output | 2 | Backing memory byte strobes |
| mem_wdata | output | 16 | Backing memory write data |
| mem_rdata | input | 16 | Backing memory read data, valid with mem_ack |
| mem_ack | input | 1 | One-cycle completion from backing memory |
| alt_grant_ack | input | 1 | Another master holds the bus; flush and suppress hits |

## Verification
The hardest case to reach is a fill that completes while `alt_grant_ack` is high. The CPU normally stays idle while another master owns the bus, so this overlap does not arise in ordinary use. The bench forces it by raising the acknowledge before it issues a read of a line that was previously cached. It then holds the acknowledge through the whole memory latency and releases it only after the CPU cycle has ended. A second read of the same line must then miss again, which shows that the fill did not set the valid flag. A separate conflict test uses two addresses that share an index and differ only in their tag bits, to exercise the XOR compare.

// File: rtl/wt_cache_pkg.sv
package wt_cache_pkg;

    typedef enum logic [2:0] {
        CS_IDLE,
        CS_LOOKUP,
        CS_FILL,
        CS_WRITE,
        CS_ACK
    } cache_state_e;

endpackage

// File: rtl/wt_cache_sram.sv
module wt_cache_sram #(
    parameter int LANES  = 1,
    parameter int LANE_W = 8,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic [LANES-1:0]          wr_en,
    input  logic [AW-1:0]             addr,
    input  logic [LANES*LANE_W-1:0]   wdata,
    output logic [LANES*LANE_W-1:0]   rdata
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en[g]) begin
                store[addr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = store[addr];
    end

endmodule

// File: rtl/wt_cache_valid.sv
module wt_cache_valid #(
    parameter int LINES = 16,
    localparam int IW   = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             set_en,
    input  logic [IW-1:0]    set_idx,
    output logic [LINES-1:0] valid_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (flush) begin
            valid_q <= '0;
        end else if (set_en) begin
            valid_q[set_idx] <= 1'b1;
        end
    end

endmodule

// File: rtl/wt_cache_tagcmp.sv
module wt_cache_tagcmp #(
    parameter int TAG_W = 16
) (
    input  logic [TAG_W-1:0] stored_tag,
    input  logic [TAG_W-1:0] addr_tag,
    output logic             match
);

    logic [TAG_W-1:0] diff;

    for (genvar b = 0; b < TAG_W; b++) begin : g_bit
        assign diff[b] = stored_tag[b] ^ addr_tag[b];
    end

    assign match = ~|diff;

endmodule

// File: rtl/wt_cache_ctrl.sv
module wt_cache_ctrl
    import wt_cache_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_req,
    input  logic req_we,
    input  logic hit,
    input  logic mem_ack,
    output logic cap_en,
    output logic hit_load,
    output logic fill_en,
    output logic upd_en,
    output logic mem_req,
    output logic cpu_ack
);

    cache_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_IDLE:   if (cpu_req) state_d = CS_LOOKUP;
            CS_LOOKUP: begin
                if (req_we)   state_d = CS_WRITE;
                else if (hit) state_d = CS_ACK;
                else          state_d = CS_FILL;
            end
            CS_FILL:   if (mem_ack) state_d = CS_ACK;
            CS_WRITE:  if (mem_ack) state_d = CS_ACK;
            CS_ACK:    if (!cpu_req) state_d = CS_IDLE;
            default:   state_d = CS_IDLE;
        endcase
    end

    always_comb begin
        cap_en   = 1'b0;
        hit_load = 1'b0;
        fill_en  = 1'b0;
        upd_en   = 1'b0;
        mem_req  = 1'b0;
        cpu_ack  = 1'b0;
        unique case (state_q)
            CS_IDLE:   cap_en   = cpu_req;
            CS_LOOKUP: hit_load = !req_we && hit;
            CS_FILL: begin
                mem_req = 1'b1;
                fill_en = mem_ack;
            end
            CS_WRITE: begin
                mem_req = 1'b1;
                upd_en  = mem_ack && hit;
            end
            CS_ACK:    cpu_ack  = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/wt_cache.sv
module wt_cache #(
    parameter int CACHE_BYTES = 8192,
    parameter int ADDR_W      = 24,
    localparam int DATA_W     = 16,
    localparam int LANES      = DATA_W / 8,
    localparam int OFF_W      = $clog2(LANES),
    localparam int WA_W       = ADDR_W - OFF_W,
    localparam int LINES      = CACHE_BYTES / LANES,
    localparam int IDX_W      = $clog2(LINES),
    localparam int TAG_W      = WA_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [WA_W-1:0]   cpu_addr,
    input  logic [LANES-1:0]  cpu_be,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ack,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WA_W-1:0]   mem_addr,
    output logic [LANES-1:0]  mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    input  logic              alt_grant_ack
);

    logic [WA_W-1:0]   req_addr;
    logic              req_we;
    logic [LANES-1:0]  req_be;
    logic [DATA_W-1:0] req_wdata;
    logic [DATA_W-1:0] rdata_q;

    logic [IDX_W-1:0]  req_idx;
    logic [TAG_W-1:0]  req_tag;
    logic [TAG_W-1:0]  stored_tag;
    logic [DATA_W-1:0] line_data;
    logic [LINES-1:0]  valid_q;
    logic              tag_match;
    logic              hit;

    logic cap_en, hit_load, fill_en, upd_en;

    logic [LANES-1:0]  data_we;
    logic [DATA_W-1:0] data_wr;

    assign req_idx = req_addr[IDX_W-1:0];
    assign req_tag = req_addr[WA_W-1:IDX_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_addr  <= '0;
            req_we    <= 1'b0;
            req_be    <= '0;
            req_wdata <= '0;
        end else if (cap_en) begin
            req_addr  <= cpu_addr;
            req_we    <= cpu_we;
            req_be    <= cpu_be;
            req_wdata <= cpu_wdata;
        end
    end

    wt_cache_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_req  (cpu_req),
        .req_we   (req_we),
        .hit      (hit),
        .mem_ack  (mem_ack),
        .cap_en   (cap_en),
        .hit_load (hit_load),
        .fill_en  (fill_en),
        .upd_en   (upd_en),
        .mem_req  (mem_req),
        .cpu_ack  (cpu_ack)
    );

    wt_cache_valid #(.LINES(LINES)) u_valid (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (alt_grant_ack),
        .set_en  (fill_en && !alt_grant_ack),
        .set_idx (req_idx),
        .valid_q (valid_q)
    );

    wt_cache_sram #(.LANES(1), .LANE_W(TAG_W), .DEPTH(LINES)) u_tags (
        .clk   (clk),
        .wr_en (fill_en),
        .addr  (req_idx),
        .wdata (req_tag),
        .rdata (stored_tag)
    );

    assign data_we = fill_en ? {LANES{1'b1}} : (upd_en ? req_be : '0);
    assign data_wr = fill_en ? mem_rdata : req_wdata;

    wt_cache_sram #(.LANES(LANES), .LANE_W(8), .DEPTH(LINES)) u_data (
        .clk   (clk),
        .wr_en (data_we),
        .addr  (req_idx),
        .wdata (data_wr),
        .rdata (line_data)
    );

    wt_cache_tagcmp #(.TAG_W(TAG_W)) u_cmp (
        .stored_tag (stored_tag),
        .addr_tag   (req_tag),
        .match      (tag_match)
    );

    assign hit = valid_q[req_idx] && tag_match && !alt_grant_ack;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (hit_load) begin
            rdata_q <= line_data;
        end else if (fill_en) begin
            rdata_q <= mem_rdata;
        end
    end

    assign cpu_rdata = rdata_q;
    assign mem_we    = req_we;
    assign mem_addr  = req_addr;
    assign mem_be    = req_we ? req_be : {LANES{1'b1}};
    assign mem_wdata = req_wdata;

endmodule

// File: rtl/wt_cache_chk.sv
module wt_cache_chk #(
    parameter int WA_W  = 23,
    parameter int LINES = 4096,
    localparam int IW   = $clog2(LINES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_req,
    input logic [WA_W-1:0]  cpu_addr,
    input logic [1:0]       cpu_be,
    input logic [15:0]      cpu_wdata,
    input logic             cpu_ack,
    input logic             mem_req,
    input logic             mem_we,
    input logic [WA_W-1:0]  mem_addr,
    input logic [1:0]       mem_be,
    input logic [15:0]      mem_wdata,
    input logic             mem_ack,
    input logic             alt_grant_ack,
    input logic [LINES-1:0] valid_q,
    input logic [IW-1:0]    req_idx
);

    p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(alt_grant_ack) |-> (valid_q == '0));

    p_write_forward_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |->
            (mem_addr == cpu_addr && mem_wdata == cpu_wdata && mem_be == cpu_be));

    p_ack_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && cpu_req) |=> cpu_ack);

    p_ack_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && !cpu_req) |=> !cpu_ack);

    p_memreq_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    p_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req, cpu_ack}));

    p_fill_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && !mem_we && !alt_grant_ack) |=> valid_q[req_idx]);

    p_no_fill_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && alt_grant_ack) |=> !valid_q[req_idx]);

endmodule

bind wt_cache wt_cache_chk #(.WA_W(WA_W), .LINES(LINES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_req       (cpu_req),
    .cpu_addr      (cpu_addr),
    .cpu_be        (cpu_be),
    .cpu_wdata     (cpu_wdata),
    .cpu_ack       (cpu_ack),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_be        (mem_be),
    .mem_wdata     (mem_wdata),
    .mem_ack       (mem_ack),
    .alt_grant_ack (alt_grant_ack),
    .valid_q       (valid_q),
    .req_idx       (req_idx)
);

// File: tb/wt_cache_bench.sv
module wt_cache_bench;

    localparam int WA = 23;
    localparam int MEM_LAT = 3;
    localparam int CONFLICT_STEP = 4096;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0;
    logic          cpu_we = 1'b0;
    logic [WA-1:0] cpu_addr = '0;
    logic [1:0]    cpu_be = 2'b11;
    logic [15:0]   cpu_wdata = '0;
    logic [15:0]   cpu_rdata;
    logic          cpu_ack;
    logic          mem_req;
    logic          mem_we;
    logic [WA-1:0] mem_addr;
    logic [1:0]    mem_be;
    logic [15:0]   mem_wdata;
    logic [15:0]   mem_rdata = '0;
    logic          mem_ack = 1'b0;
    logic          alt_grant_ack = 1'b0;

    int n_checks = 0;
    int n_fails = 0;
    int n_mrd = 0;
    int n_mwr = 0;
    logic [15:0] bmem [int];

    always #2 clk = ~clk;

    wt_cache u_wt_cache (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_be(cpu_be),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .alt_grant_ack(alt_grant_ack)
    );

    function automatic logic [15:0] model_rd(input logic [WA-1:0] a);
        if (bmem.exists(int'(a))) return bmem[int'(a)];
        return a[15:0] ^ 16'h5A3C;
    endfunction

    // backing memory model: fixed latency, one-cycle ack
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                cnt++;
                if (cnt == MEM_LAT) begin
                    cnt = 0;
                    if (mem_we) begin
                        logic [15:0] w;
                        w = model_rd(mem_addr);
                        if (mem_be[1]) w[15:8] = mem_wdata[15:8];
                        if (mem_be[0]) w[7:0]  = mem_wdata[7:0];
                        bmem[int'(mem_addr)] = w;
                        n_mwr++;
                    end else begin
                        mem_rdata = model_rd(mem_addr);
                        n_mrd++;
                    end
                    mem_ack = 1'b1;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cpu_read(input logic [WA-1:0] a, input int hold,
                            output logic [15:0] d, output int lat);
        @(negedge clk);
        cpu_addr = a; cpu_we = 1'b0; cpu_be = 2'b11; cpu_req = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!cpu_ack && lat < 100);
        d = cpu_rdata;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk("R11 ack held", cpu_ack, 1);
        end
        cpu_req = 1'b0;
        @(negedge clk);
        chk("R11 ack released", cpu_ack, 0);
    endtask

    task automatic cpu_write(input logic [WA-1:0] a, input logic [1:0] be,
                             input logic [15:0] d);
        int lat = 0;
        int w0 = n_mwr;
        @(negedge clk);
        cpu_addr = a; cpu_we = 1'b1; cpu_be = be; cpu_wdata = d; cpu_req = 1'b1;
        do begin
            @(negedge clk);
            lat++;
        end while (!cpu_ack && lat < 100);
        chk("R2 one memory write before ack", n_mwr - w0, 1);
        cpu_req = 1'b0;
        cpu_we = 1'b0;
        @(negedge clk);
    endtask

    // read and check data, memory-read delta and optional hit latency
    task automatic read_expect(input string tag, input logic [WA-1:0] a,
                               input int exp_mrd);
        logic [15:0] d;
        int lat;
        int r0 = n_mrd;
        cpu_read(a, 0, d, lat);
        chk({tag, " data"}, d, model_rd(a));
        chk({tag, " memory reads"}, n_mrd - r0, exp_mrd);
        if (exp_mrd == 0) chk({tag, " hit latency"}, lat, 2);
    endtask

    task automatic t_reset();
        chk("R1 reset cpu_ack", cpu_ack, 0);
        chk("R1 reset mem_req", mem_req, 0);
    endtask

    task automatic t_cold_and_hit();
        read_expect("R1 R3 cold miss", 23'h000100, 1);
        read_expect("R4 read hit", 23'h000100, 0);
        read_expect("R1 second cold miss", 23'h0002F0, 1);
        read_expect("R4 second hit", 23'h0002F0, 0);
    endtask

    task automatic t_write_hit();
        cpu_write(23'h000100, 2'b11, 16'h1234);
        chk("R2 memory holds write", model_rd(23'h000100), 16'h1234);
        read_expect("R6 write hit then read", 23'h000100, 0);
    endtask

    task automatic t_byte_write();
        cpu_write(23'h000100, 2'b10, 16'hBEEF);
        chk("R7 upper byte in memory", model_rd(23'h000100), 16'hBE34);
        read_expect("R7 upper byte cached", 23'h000100, 0);
        cpu_write(23'h000100, 2'b01, 16'h00C1);
        read_expect("R7 lower byte cached", 23'h000100, 0);
        chk("R7 merged word", model_rd(23'h000100), 16'hBEC1);
    endtask

    task automatic t_write_miss();
        cpu_write(23'h000777, 2'b11, 16'hCAFE);
        read_expect("R5 write miss not allocated", 23'h000777, 1);
        read_expect("R5 then hit", 23'h000777, 0);
    endtask

    task automatic t_conflict();
        logic [WA-1:0] a = 23'h000100;
        logic [WA-1:0] b = a + CONFLICT_STEP;
        read_expect("R10 conflicting tag misses", b, 1);
        read_expect("R10 evicted line misses", a, 1);
        read_expect("R10 refilled line hits", a, 0);
    endtask

    task automatic t_ack_hold();
        logic [15:0] d;
        int lat;
        cpu_read(23'h000100, 3, d, lat);
        chk("R11 data while held", d, model_rd(23'h000100));
    endtask

    task automatic t_flush();
        read_expect("R8 warm line x", 23'h000010, 1);
        read_expect("R8 warm line y", 23'h000011, 1);
        @(negedge clk);
        alt_grant_ack = 1'b1;
        @(negedge clk);
        alt_grant_ack = 1'b0;
        read_expect("R8 flushed x misses", 23'h000010, 1);
        read_expect("R8 flushed y misses", 23'h000011, 1);
        read_expect("R8 previous line misses", 23'h000100, 1);
    endtask

    task automatic t_pending();
        read_expect("R9 warm line", 23'h000020, 0 + 1);
        read_expect("R9 warm hit", 23'h000020, 0);
        @(negedge clk);
        alt_grant_ack = 1'b1;
        read_expect("R9 no hit while granted", 23'h000020, 1);
        @(negedge clk);
        alt_grant_ack = 1'b0;
        read_expect("R9 fill under grant stays invalid", 23'h000020, 1);
        read_expect("R9 later hit", 23'h000020, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_cold_and_hit();
        t_write_hit();
        t_byte_write();
        t_write_miss();
        t_conflict();
        t_ack_hold();
        t_flush();
        t_pending();
        repeat (2) @(negedge clk);
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule